// File: doc/BRIEF.md
# Adaptive JTAG Test-Clock Generator

This block drives the test clock, mode-select and data-in lines of a JTAG debug probe, one bit at a time. The host offers a bit through a valid/ready handshake. The bit carries the mode-select and data-in values. The block places those values on the lines while the test clock is low and then produces one full clock pulse. It captures the data-out line at the rising edge. When the falling edge is driven, it returns the captured bit with a single-cycle done pulse.

Two pacing modes are selectable.

- **Fixed-rate mode.** Each clock phase lasts a programmable number of probe clock cycles. The return clock is ignored, and a floor on the phase length keeps the test clock at or below 10 MHz.
- **Adaptive mode.** Each edge is held back until the target has echoed the previous edge on its return clock. The target derives that return clock through its own synchronizer, which runs on the CPU clock, so the test clock stops whenever the target CPU clock stops. The return clock is resynchronized with a two-flop chain before it is compared with the test clock.

A programmable echo timeout raises a status flag when an echo is late. The flag never aborts the bit in progress.

Top module: `jtag_tck_gen`

## Requirements
- R1: After reset the test clock `tck` is 0, `tms` is 1, `tdi` is 0, `reqReady` is 1, and both `doneValid` and `echoLate` are 0.
- R2: `reqReady` is 1 only while no bit is in progress, and a bit is accepted on a clock edge where `reqValid` and `reqReady` are both 1. The accepted `reqTms`/`reqTdi` appear on `tms`/`tdi` in the cycle after acceptance, while `tck` is still 0. They stay unchanged until the next accepted bit.
- R3: Every accepted bit produces exactly one `tck` pulse, a rise followed by a fall. `doneValid` is a one-cycle pulse in the cycle `tck` falls. `doneTdo` equals the value `tdo` had at the edge where `tck` rose, not any later value.
- R4: In fixed mode (`modeAdaptive`=0), `tck` stays high for exactly H probe cycles, where H = max(`divHalf`, MIN_HALF). Each rise comes at least H cycles after the previous fall, and `rtck` has no effect on either phase.
- R5: MIN_HALF = ceil(CLK_HZ / (2·MAX_TCK_HZ)), which is 10 with the defaults (200 MHz probe clock, 10 MHz ceiling). Any `divHalf` below it, including 0, gives a high phase of 10 cycles.
- R6: In adaptive mode (`modeAdaptive`=1), `tck` rises only after the resynchronized `rtck` is 0 and falls only after it is 1. Each `tck` edge therefore follows the matching `rtck` edge by at least 2 probe cycles.
- R7: If `rtck` stops changing in adaptive mode, `tck` holds its level indefinitely and no done pulse is issued. When the echo arrives, the same bit completes normally.
- R8: `echoLate` rises exactly `echoLimit` cycles after a `tck` edge whose echo is still awaited in adaptive mode. It returns to 0 at the next `tck` edge and stays 0 in fixed mode. A limit of 0 disables it.
- R9: In adaptive mode the high phase of `tck` is at least the echo latency (from the `tck` rise to the `rtck` rise) plus 2 cycles. A slower target clock gives a longer high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Probe clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeAdaptive | input | 1 | 1 = pace edges by the return clock, 0 = fixed rate; change only while idle |
| divHalf | input | CNT_W | Fixed-mode half period in probe cycles (floored at MIN_HALF) |
| echoLimit | input | CNT_W | Cycles to wait for an echo before `echoLate` is raised; 0 disables |
| reqValid | input | 1 | Host offers a bit |
| reqTms | input | 1 | Mode-select value for the offered bit |
| reqTdi | input | 1 | Data-in value for the offered bit |
| reqReady | output | 1 | Block can accept a bit |
| doneValid | output | 1 | One-cycle pulse when the bit's falling edge is driven |
| doneTdo | output | 1 | Data-out value captured at the rising edge |
| echoLate | output | 1 | Echo wait has exceeded `echoLimit` |
| tck | output | 1 | Test clock to the target |
| tms | output | 1 | Mode-select line to the target |
| tdi | output | 1 | Data-in line to the target |
| rtck | input | 1 | Return clock from the target (asynchronous) |
| tdo | input | 1 | Data-out line from the target |

## Verification
The bench models the target's return path as three flops on a separate target clock that can be gated.

- **Fixed mode.** It runs fixed mode with the target clock stopped, which shows that the return clock is ignored. It also drives half periods below and above the floor, which separates clamping from plain division.
- **Adaptive mode.** It runs adaptive mode with a fast and a slow target clock. The difference in the high phase shows the edges really follow the echo and are not a fixed delay.
- **Frozen target.** A frozen target clock in the middle of a bit shows that the clock holds and the timeout flag rises at the programmed cycle without aborting the bit.
- **Capture timing.** `tdo` is flipped just after each rise, which tells rising-edge capture apart from later sampling.

// File: rtl/jtck_pkg.sv
package jtck_pkg;

  // Strobes issued by the sequencer to the datapath
  typedef struct packed {
    logic loadBit;    // latch host TMS/TDI onto the lines
    logic driveRise;  // raise TCK and capture TDO
    logic driveFall;  // lower TCK
    logic clrCnt;     // restart the phase/echo counter
    logic echoWait;   // an echo is being awaited (adaptive pacing)
  } jtck_strobe_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } jtck_phase_e;

endpackage

// File: rtl/jtck_sync.sv
module jtck_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stage;

  always_ff @(posedge clk) begin
    if (!rstN) stage[0] <= 1'b0;
    else       stage[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) stage[g] <= 1'b0;
      else       stage[g] <= stage[g-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/jtck_ctrl.sv
module jtck_ctrl
  import jtck_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         modeAdaptive,
  input  logic         reqValid,
  input  logic         halfDone,
  input  logic         rtckSync,
  output logic         reqReady,
  output jtck_strobe_t strb,
  output logic         doneValid
);
  jtck_phase_e phase, phaseNxt;
  logic        riseOk, fallOk;

  // An edge may go out once the pacing condition of the current mode holds
  assign riseOk = modeAdaptive ? !rtckSync : halfDone;
  assign fallOk = modeAdaptive ?  rtckSync : halfDone;

  always_comb begin
    phaseNxt      = phase;
    strb          = '0;
    strb.echoWait = modeAdaptive && (phase != PH_IDLE);
    unique case (phase)
      PH_IDLE: begin
        if (reqValid) begin
          strb.loadBit = 1'b1;
          strb.clrCnt  = 1'b1;
          phaseNxt     = PH_LOW;
        end
      end
      PH_LOW: begin
        if (riseOk) begin
          strb.driveRise = 1'b1;
          strb.clrCnt    = 1'b1;
          phaseNxt       = PH_HIGH;
        end
      end
      PH_HIGH: begin
        if (fallOk) begin
          strb.driveFall = 1'b1;
          strb.clrCnt    = 1'b1;
          phaseNxt       = PH_IDLE;
        end
      end
      default: phaseNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      doneValid <= 1'b0;
    end else begin
      phase     <= phaseNxt;
      doneValid <= strb.driveFall;
    end
  end

  assign reqReady = (phase == PH_IDLE);

  // R3: the done indication lasts a single cycle
  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R2: a bit in flight blocks further requests until it completes
  assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
endmodule

// File: rtl/jtck_dp.sv
module jtck_dp
  import jtck_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MIN_HALF    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeAdaptive,
  input  logic [CNT_W-1:0] divHalf,
  input  logic [CNT_W-1:0] echoLimit,
  input  jtck_strobe_t     strb,
  input  logic             reqTms,
  input  logic             reqTdi,
  input  logic             rtck,
  input  logic             tdo,
  output logic             tck,
  output logic             tms,
  output logic             tdi,
  output logic             doneTdo,
  output logic             rtckSync,
  output logic             halfDone,
  output logic             echoLate
);
  localparam logic [CNT_W-1:0] MIN_HALF_V = CNT_W'(MIN_HALF);
  localparam logic [CNT_W-1:0] CNT_MAX    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] effHalf;
  logic             lateHit;

  jtck_sync #(.STAGES(SYNC_STAGES)) u_rtckSync (
    .clk (clk),
    .rstN(rstN),
    .din (rtck),
    .dout(rtckSync)
  );

  // Phase length floor keeps the test clock under its ceiling
  assign effHalf  = (divHalf < MIN_HALF_V) ? MIN_HALF_V : divHalf;
  assign halfDone = (cnt >= effHalf - ONE);
  assign lateHit  = strb.echoWait && (echoLimit != '0) && (cnt >= echoLimit - ONE);

  // Saturating phase counter, restarted at every edge and every accept
  always_ff @(posedge clk) begin
    if (!rstN)              cnt <= '0;
    else if (strb.clrCnt)   cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tck     <= 1'b0;
      tms     <= 1'b1;
      tdi     <= 1'b0;
      doneTdo <= 1'b0;
    end else begin
      if (strb.loadBit) begin
        tms <= reqTms;
        tdi <= reqTdi;
      end
      if (strb.driveRise) begin
        tck     <= 1'b1;
        doneTdo <= tdo;
      end else if (strb.driveFall) begin
        tck <= 1'b0;
      end
    end
  end

  // Status only: the flag never stops the edge sequencing
  always_ff @(posedge clk) begin
    if (!rstN)            echoLate <= 1'b0;
    else if (strb.clrCnt) echoLate <= 1'b0;
    else if (lateHit)     echoLate <= 1'b1;
  end

  // R6: adaptive rise only after the low echo has been resynchronized
  assert_rise_after_low_echo_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeAdaptive && $rose(tck)) |-> !$past(rtckSync));

  // R6: adaptive fall only after the high echo has been resynchronized
  assert_fall_after_high_echo_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeAdaptive && $fell(tck)) |-> $past(rtckSync));

  // R5: a fixed-mode high phase never undercuts the rate floor
  assert_fixed_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!modeAdaptive && $fell(tck)) |-> ($past(cnt) >= MIN_HALF_V - ONE));

  // R2: data lines are frozen while the clock is high
  assert_lines_stable_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(tck) && tck) |-> ($stable(tms) && $stable(tdi)));

  // R8: the late flag appears only while an echo is awaited
  assert_late_needs_wait_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(echoLate) |-> $past(strb.echoWait));
endmodule

// File: rtl/jtag_tck_gen.sv
module jtag_tck_gen
  import jtck_pkg::*;
#(
  parameter int CLK_HZ      = 200_000_000,
  parameter int MAX_TCK_HZ  = 10_000_000,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeAdaptive,
  input  logic [CNT_W-1:0] divHalf,
  input  logic [CNT_W-1:0] echoLimit,
  input  logic             reqValid,
  input  logic             reqTms,
  input  logic             reqTdi,
  output logic             reqReady,
  output logic             doneValid,
  output logic             doneTdo,
  output logic             echoLate,
  output logic             tck,
  output logic             tms,
  output logic             tdi,
  input  logic             rtck,
  input  logic             tdo
);
  localparam int MIN_HALF = (CLK_HZ + 2*MAX_TCK_HZ - 1) / (2*MAX_TCK_HZ);

  jtck_strobe_t strb;
  logic         rtckSync;
  logic         halfDone;

  jtck_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .modeAdaptive(modeAdaptive),
    .reqValid    (reqValid),
    .halfDone    (halfDone),
    .rtckSync    (rtckSync),
    .reqReady    (reqReady),
    .strb        (strb),
    .doneValid   (doneValid)
  );

  jtck_dp #(
    .CNT_W      (CNT_W),
    .MIN_HALF   (MIN_HALF),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .modeAdaptive(modeAdaptive),
    .divHalf     (divHalf),
    .echoLimit   (echoLimit),
    .strb        (strb),
    .reqTms      (reqTms),
    .reqTdi      (reqTdi),
    .rtck        (rtck),
    .tdo         (tdo),
    .tck         (tck),
    .tms         (tms),
    .tdi         (tdi),
    .doneTdo     (doneTdo),
    .rtckSync    (rtckSync),
    .halfDone    (halfDone),
    .echoLate    (echoLate)
  );

  // R2: the host sees ready only with the clock parked low
  assert_ready_clock_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !tck);

  // R3: completion coincides with the falling edge
  assert_done_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $fell(tck));
endmodule

// File: tb/jtag_tck_gen_tb_top.sv
`timescale 1ns/1ps
module jtag_tck_gen_tb_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeAdaptive = 1'b0;
  logic [CNT_W-1:0] divHalf = '0;
  logic [CNT_W-1:0] echoLimit = '0;
  logic reqValid = 1'b0, reqTms = 1'b0, reqTdi = 1'b0;
  logic reqReady, doneValid, doneTdo, echoLate, tck, tms, tdi;
  logic rtck;
  logic tdo = 1'b0;

  // target echo model: three flops on a gateable target clock
  logic       tclk = 1'b0;
  logic       tclkEn = 1'b1;
  realtime    tHalf = 11.5;
  logic [2:0] tsync = 3'b000;

  int checks = 0, errors = 0;
  int cycleNo = 0;
  int riseCyc = 0, fallCyc = 0, prevFallCyc = 0, rtckRiseCyc = 0, rtckFallCyc = 0;
  int doneCyc = 0, doneCnt = 0, lateCyc = 0;
  logic lastTdo = 1'b0;
  logic prevTck = 1'b0, prevRtck = 1'b0, prevLate = 1'b0;

  always #2.5 clk = ~clk;
  always #(tHalf) tclk = ~tclk;
  always @(posedge tclk) if (tclkEn) tsync <= {tsync[1:0], tck};
  assign rtck = tsync[2];

  jtag_tck_gen dut_i (
    .clk(clk), .rstN(rstN), .modeAdaptive(modeAdaptive), .divHalf(divHalf),
    .echoLimit(echoLimit), .reqValid(reqValid), .reqTms(reqTms), .reqTdi(reqTdi),
    .reqReady(reqReady), .doneValid(doneValid), .doneTdo(doneTdo), .echoLate(echoLate),
    .tck(tck), .tms(tms), .tdi(tdi), .rtck(rtck), .tdo(tdo)
  );

  // monitor: 1 ns after each edge, stamping events with the edge number
  always @(posedge clk) begin
    cycleNo++;
    #1;
    if (tck && !prevTck) riseCyc = cycleNo;
    if (!tck && prevTck) begin prevFallCyc = fallCyc; fallCyc = cycleNo; end
    if (rtck && !prevRtck) rtckRiseCyc = cycleNo;
    if (!rtck && prevRtck) rtckFallCyc = cycleNo;
    if (echoLate && !prevLate) lateCyc = cycleNo;
    if (doneValid) begin doneCnt++; doneCyc = cycleNo; lastTdo = doneTdo; end
    prevTck = tck; prevRtck = rtck; prevLate = echoLate;
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    while (cycleNo < 150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act %0d cycles exp completion", cycleNo);
    finish_run();
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
    end
  endtask

  task automatic issueBit(input logic tmsV, input logic tdiV, input logic tdoV);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqTms = tmsV; reqTdi = tdiV; tdo = tdoV;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitRiseFlip(input logic tdoV);
    int n = 0;
    while (!tck && n < 20000) begin @(negedge clk); n++; end
    tdo = ~tdoV;   // a late change must not reach the captured bit
  endtask

  task automatic waitDone(input int startCnt, input string req);
    int n = 0;
    while (doneCnt == startCnt && n < 20000) begin @(negedge clk); n++; end
    check(doneCnt == startCnt + 1, req, "done count", doneCnt, startCnt + 1);
  endtask

  task automatic runBit(input logic tmsV, input logic tdiV, input logic tdoV, input string req);
    int s = doneCnt;
    issueBit(tmsV, tdiV, tdoV);
    waitRiseFlip(tdoV);
    waitDone(s, req);
    @(negedge clk);
  endtask

  task automatic testReset();
    check(tck == 1'b0, "R1", "tck", tck, 0);
    check(tms == 1'b1, "R1", "tms", tms, 1);
    check(tdi == 1'b0, "R1", "tdi", tdi, 0);
    check(reqReady == 1'b1, "R1", "reqReady", reqReady, 1);
    check(doneValid == 1'b0, "R1", "doneValid", doneValid, 0);
    check(echoLate == 1'b0, "R1", "echoLate", echoLate, 0);
  endtask

  task automatic testHandshake();
    int s;
    modeAdaptive = 1'b0; divHalf = 16'd12;
    s = doneCnt;
    issueBit(1'b0, 1'b1, 1'b1);
    check(tms == 1'b0 && tdi == 1'b1, "R2", "lines after accept", {tms, tdi}, 2'b01);
    check(tck == 1'b0, "R2", "tck low at load", tck, 0);
    check(reqReady == 1'b0, "R2", "ready while busy", reqReady, 0);
    waitRiseFlip(1'b1);
    waitDone(s, "R2");
    repeat (5) @(negedge clk);
    check(tms == 1'b0 && tdi == 1'b1, "R2", "lines held after bit", {tms, tdi}, 2'b01);
    check(lastTdo == 1'b1, "R3", "captured tdo", lastTdo, 1);
  endtask

  task automatic testFixed();
    modeAdaptive = 1'b0; divHalf = 16'd25; echoLimit = 16'd5;
    tclkEn = 1'b0;   // return clock frozen: fixed pacing must not care
    runBit(1'b1, 1'b0, 1'b0, "R4");
    check(fallCyc - riseCyc == 25, "R4", "high width", fallCyc - riseCyc, 25);
    check(doneCyc == fallCyc, "R3", "done with fall", doneCyc, fallCyc);
    check(lastTdo == 1'b0, "R3", "tdo rise value", lastTdo, 0);
    runBit(1'b0, 1'b0, 1'b1, "R4");
    check(riseCyc - prevFallCyc >= 25, "R4", "low width", riseCyc - prevFallCyc, 25);
    check(lastTdo == 1'b1, "R3", "tdo rise value", lastTdo, 1);
    check(echoLate == 1'b0, "R8", "no late flag in fixed mode", echoLate, 0);
    tclkEn = 1'b1;
  endtask

  task automatic testClamp();
    modeAdaptive = 1'b0; divHalf = 16'd3;
    runBit(1'b0, 1'b1, 1'b0, "R5");
    check(fallCyc - riseCyc == 10, "R5", "clamped width div=3", fallCyc - riseCyc, 10);
    divHalf = 16'd0;
    runBit(1'b1, 1'b1, 1'b1, "R5");
    check(fallCyc - riseCyc == 10, "R5", "clamped width div=0", fallCyc - riseCyc, 10);
  endtask

  task automatic testAdaptive(input realtime half, output int width);
    tHalf = half;
    modeAdaptive = 1'b1; echoLimit = 16'd0;
    repeat (60) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      runBit(i[0], ~i[0], i[0], "R6");
      check(fallCyc - rtckRiseCyc >= 2, "R6", "fall after echo", fallCyc - rtckRiseCyc, 2);
      check(riseCyc - rtckFallCyc >= 2, "R6", "rise after echo", riseCyc - rtckFallCyc, 2);
      check(fallCyc - riseCyc >= (rtckRiseCyc - riseCyc) + 2, "R9", "high vs latency",
            fallCyc - riseCyc, rtckRiseCyc - riseCyc + 2);
      check(lastTdo == i[0], "R3", "adaptive tdo", lastTdo, i[0]);
    end
    width = fallCyc - riseCyc;
  endtask

  task automatic testFreeze();
    int s;
    tHalf = 11.5; modeAdaptive = 1'b1; echoLimit = 16'd20;
    repeat (60) @(negedge clk);   // let the low level echo back first
    tclkEn = 1'b0;
    s = doneCnt;
    issueBit(1'b1, 1'b1, 1'b1);
    waitRiseFlip(1'b1);
    repeat (300) @(negedge clk);
    check(tck == 1'b1, "R7", "tck frozen high", tck, 1);
    check(doneCnt == s, "R7", "no done while frozen", doneCnt, s);
    check(echoLate == 1'b1, "R8", "late flag", echoLate, 1);
    check(lateCyc - riseCyc == 20, "R8", "late flag timing", lateCyc - riseCyc, 20);
    tclkEn = 1'b1;
    waitDone(s, "R7");
    @(negedge clk);
    check(lastTdo == 1'b1, "R7", "bit completes intact", lastTdo, 1);
    check(echoLate == 1'b0, "R8", "flag cleared at edge", echoLate, 0);
  endtask

  initial begin
    int wFast, wSlow;
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testHandshake();
    testFixed();
    testClamp();
    testAdaptive(11.5, wFast);
    testAdaptive(40.0, wSlow);
    check(wSlow > wFast, "R9", "slow target slower tck", wSlow, wFast + 1);
    testFreeze();
    finish_run();
  end
endmodule